// File: doc/BRIEF.md
# Single-Operand Increment / Rotate Unit

This unit runs the two single-register operations of an 8-bit microcontroller core that change one working register and the status flags together: increment and rotate-right-through-carry. Each cycle it reads a 16-bit instruction word and a valid strobe. It decodes the word, puts the destination register number on a register-file read port, and computes the new register value and the new status byte. It then presents both as write requests in the next cycle.

The two operations follow different flag rules. Increment leaves the carry alone and reports overflow only when it steps from the largest positive value. Rotate moves the old carry into the top bit and the old bottom bit into carry, and reports overflow as the sign bit xor the carry. The half-carry bit, the transfer bit and the interrupt-enable bit pass through unchanged. An instruction word that matches neither operation produces no write of any kind.

Top module: `unary_alu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rf_wr_en, flags_we and pc_step are low.
- R2: An increment is recognised when (opcode & 16'hFE0F) == 16'h9403 and a rotate when (opcode & 16'hFE0F) == 16'h9407. rf_rd_idx always equals opcode[8:4], and rf_wr_idx carries the opcode[8:4] of the issued instruction.
- R3: An increment writes (operand + 1) mod 256 and leaves flag bit 0 (carry) at its input value.
- R4: In the status byte, bit 1 is zero, bit 2 is negative, bit 3 is overflow and bit 4 is sign. After an increment, zero is set when the result is 0, negative equals result bit 7, overflow is set exactly when the operand was 8'h7F, and sign is negative xor overflow.
- R5: A rotate writes {old carry, operand[7:1]} and sets the carry (bit 0) to operand bit 0.
- R6: After a rotate, zero and negative come from the result, overflow is negative xor the new carry, and sign is negative xor overflow.
- R7: Status bits 7, 6 and 5 leave both operations with the values they had on input.
- R8: If valid is low, or the opcode matches neither pattern, the cycle that follows has no register write, no status write and no PC step.
- R9: The results of an instruction issued in one cycle appear in the next cycle, with rf_wr_en, flags_we and pc_step high together for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | The instruction word is presented this cycle |
| opcode | input | 16 | Instruction word |
| rf_rd_idx | output | 5 | Register-file read index (combinational) |
| rf_rd_data | input | 8 | Operand read from the register file |
| rf_wr_en | output | 1 | Register write request |
| rf_wr_idx | output | 5 | Register write index |
| rf_wr_data | output | 8 | Register write value |
| flags_in | input | 8 | Current status byte |
| flags_we | output | 1 | Status byte write request |
| flags_out | output | 8 | New status byte |
| pc_step | output | 1 | Advance program counter by one |

## Verification
In a rotate, the carry is consumed and produced in the same cycle. The old carry becomes result bit 7 while operand bit 0 becomes the new carry, and overflow is computed from that new carry. The bench drives rotates with all four combinations of incoming carry and operand bit 0, using operands such as 8'h01 with carry set (expected 8'h80, status 8'h15). It compares the written value and every flag bit against a model built from the rules. Increments at 8'h7F and 8'hFF show that overflow and wrap-to-zero are judged on the operand and the result respectively, while the carry stays untouched.

// File: rtl/unary_alu.sv
module unary_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [15:0] opcode,
  output logic [4:0]  rf_rd_idx,
  input  logic [7:0]  rf_rd_data,
  output logic        rf_wr_en,
  output logic [4:0]  rf_wr_idx,
  output logic [7:0]  rf_wr_data,
  input  logic [7:0]  flags_in,
  output logic        flags_we,
  output logic [7:0]  flags_out,
  output logic        pc_step
);
  localparam logic [15:0] SEL_MASK = 16'hFE0F;
  localparam logic [15:0] INC_CODE = 16'h9403;
  localparam logic [15:0] ROR_CODE = 16'h9407;
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4;

  logic       is_inc, is_ror, do_op;
  logic [7:0] res;
  logic       c_new, v_new, n_new;
  logic [7:0] flags_nxt;

  assign rf_rd_idx = opcode[8:4];
  assign is_inc    = op_valid && ((opcode & SEL_MASK) == INC_CODE);
  assign is_ror    = op_valid && ((opcode & SEL_MASK) == ROR_CODE);
  assign do_op     = is_inc || is_ror;

  always_comb begin
    if (is_ror) begin
      res   = {flags_in[FC], rf_rd_data[7:1]};
      c_new = rf_rd_data[0];
      n_new = res[7];
      v_new = n_new ^ c_new;
    end else begin
      res   = rf_rd_data + 8'd1;
      c_new = flags_in[FC];
      n_new = res[7];
      v_new = (rf_rd_data == 8'h7F);
    end
    flags_nxt        = flags_in;
    flags_nxt[FC]    = c_new;
    flags_nxt[FZ]    = (res == 8'h00);
    flags_nxt[FN]    = n_new;
    flags_nxt[FV]    = v_new;
    flags_nxt[FS]    = n_new ^ v_new;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_wr_en   <= 1'b0;
      flags_we   <= 1'b0;
      pc_step    <= 1'b0;
      rf_wr_idx  <= '0;
      rf_wr_data <= '0;
      flags_out  <= '0;
    end else begin
      rf_wr_en  <= do_op;
      flags_we  <= do_op;
      pc_step   <= do_op;
      flags_out <= do_op ? flags_nxt : flags_in;
      if (do_op) begin
        rf_wr_idx  <= opcode[8:4];
        rf_wr_data <= res;
      end
    end
  end

  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!rf_wr_en && !flags_we && !pc_step));

  a_r9_writes_paired: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (flags_we && pc_step));

  a_r2_dest_index: assert property (@(posedge clk) disable iff (!rst_n)
    do_op |=> (rf_wr_idx == $past(opcode[8:4])));

  a_r3_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    is_inc |=> (flags_out[FC] == $past(flags_in[FC])));

  a_r5_carry_through: assert property (@(posedge clk) disable iff (!rst_n)
    is_ror |=> (flags_out[FC] == $past(rf_rd_data[0])) && (rf_wr_data[7] == $past(flags_in[FC])));

  a_r7_upper_bits: assert property (@(posedge clk) disable iff (!rst_n)
    do_op |=> (flags_out[7:5] == $past(flags_in[7:5])));
endmodule

// File: tb/test_unary_alu.sv
module test_unary_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [15:0] opcode = 16'h0000;
  logic [4:0]  rf_rd_idx;
  logic [7:0]  rf_rd_data = 8'h00;
  logic        rf_wr_en;
  logic [4:0]  rf_wr_idx;
  logic [7:0]  rf_wr_data;
  logic [7:0]  flags_in = 8'h00;
  logic        flags_we;
  logic [7:0]  flags_out;
  logic        pc_step;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  unary_alu i_unary_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .flags_in(flags_in), .flags_we(flags_we), .flags_out(flags_out),
    .pc_step(pc_step)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc_inc(input logic [4:0] r);
    return 16'h9403 | (16'(r) << 4);
  endfunction

  function automatic logic [15:0] enc_ror(input logic [4:0] r);
    return 16'h9407 | (16'(r) << 4);
  endfunction

  task automatic issue(input logic [15:0] op, input logic [7:0] val, input logic [7:0] fl);
    @(negedge clk);
    op_valid = 1'b1; opcode = op; rf_rd_data = val; flags_in = fl;
    #1 check("R2", "read index", 16'(rf_rd_idx), 16'(op[8:4]));
    @(posedge clk); #1;
    op_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1", "wr_en in reset", 16'(rf_wr_en), 16'd0);
    check("R1", "flags_we in reset", 16'(flags_we), 16'd0);
    check("R1", "pc_step in reset", 16'(pc_step), 16'd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "pc_step after reset", 16'(pc_step), 16'd0);
  endtask

  task automatic t_inc(input logic [4:0] r, input logic [7:0] val, input logic [7:0] fl);
    logic [7:0] e_res, e_fl;
    logic z, n, v;
    e_res = 8'((int'(val) + 1) % 256);
    z = (e_res == 0); n = e_res[7]; v = (val == 8'h7F);
    e_fl = {fl[7:5], n ^ v, v, n, z, fl[0]};
    issue(enc_inc(r), val, fl);
    check("R3", "inc result", 16'(rf_wr_data), 16'(e_res));
    check("R4", "inc flags", 16'(flags_out), 16'(e_fl));
    check("R2", "inc wr idx", 16'(rf_wr_idx), 16'(r));
    check("R9", "inc strobes", {13'd0, rf_wr_en, flags_we, pc_step}, 16'd7);
  endtask

  task automatic t_ror(input logic [4:0] r, input logic [7:0] val, input logic [7:0] fl);
    logic [7:0] e_res, e_fl;
    logic c, z, n, v;
    e_res = (val >> 1) + (fl[0] ? 8'h80 : 8'h00);
    c = val[0]; z = (e_res == 0); n = e_res[7]; v = n ^ c;
    e_fl = {fl[7:5], n ^ v, v, n, z, c};
    issue(enc_ror(r), val, fl);
    check("R5", "ror result", 16'(rf_wr_data), 16'(e_res));
    check("R6", "ror flags", 16'(flags_out), 16'(e_fl));
    check("R2", "ror wr idx", 16'(rf_wr_idx), 16'(r));
  endtask

  task automatic t_known;
    t_inc(5'd5, 8'h7F, 8'h00);
    check("R4", "inc 7F status", 16'(flags_out), 16'h000C);
    t_inc(5'd5, 8'hFF, 8'h00);
    check("R4", "inc FF status", 16'(flags_out), 16'h0002);
    t_ror(5'd0, 8'h11, 8'h00);
    check("R6", "ror 11 value", 16'(rf_wr_data), 16'h0008);
    check("R6", "ror 11 status", 16'(flags_out), 16'h0019);
    t_ror(5'd31, 8'h01, 8'h01);
    check("R5", "ror carry both", 16'(flags_out), 16'h0015);
  endtask

  task automatic t_carry_kept;
    t_inc(5'd17, 8'h10, 8'hE1);
    check("R3", "carry kept set", 16'(flags_out[0]), 16'd1);
    check("R7", "upper bits inc", 16'(flags_out[7:5]), 16'h7);
    t_ror(5'd9, 8'h80, 8'hA0);
    check("R7", "upper bits ror", 16'(flags_out[7:5]), 16'h5);
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 24; k++) begin
      logic [7:0] v8;
      v8 = 8'((k * 53 + 7) % 256);
      t_inc(5'(k), v8, 8'((k * 29) % 256));
      t_ror(5'(31 - k), v8, 8'((k * 71) % 256));
    end
  endtask

  task automatic t_ignored;
    @(negedge clk);
    op_valid = 1'b1; opcode = 16'h9404; rf_rd_data = 8'h33; flags_in = 8'h00;
    @(posedge clk); #1;
    check("R8", "unmatched opcode", {13'd0, rf_wr_en, flags_we, pc_step}, 16'd0);
    @(negedge clk);
    op_valid = 1'b0; opcode = enc_inc(5'd3);
    @(posedge clk); #1;
    check("R8", "valid low", {13'd0, rf_wr_en, flags_we, pc_step}, 16'd0);
  endtask

  task automatic t_single_pulse;
    t_inc(5'd1, 8'h00, 8'h00);
    @(posedge clk); #1;
    check("R9", "pc_step one cycle", 16'(pc_step), 16'd0);
    check("R9", "wr_en one cycle", 16'(rf_wr_en), 16'd0);
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_known();
    t_carry_kept();
    t_ignored();
    t_single_pulse();
    t_sweep();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule